// File: doc/BRIEF.md
# Free-Running Capture/Compare Timer

A 16-bit up-counter that never clears runs off the system clock through a power-of-two prescaler. Two edge-sensitive capture inputs take snapshots of the counter, so software can measure the time between external events. A single compare register is watched against the counter, and each match flips a compare output pin. Capture channel 1 has its own snapshot register. Capture channel 2 writes its snapshot into the second general register, R2, which software can also write.

Software uses a simple register port: a single-cycle write strobe and a combinational read mux. Four sticky cause flags record capture 1, capture 2, compare match and counter wrap. Each of the four has an interrupt enable. Two extra sticky bits mark a capture that overwrote an unread snapshot. All flags are cleared by writing one to them.

Top module: `cap_cmp_timer`

## Requirements
- R1: While reset is held, every register, all flags, `cmp_out` and `irq` are zero.
- R2: The counter advances by one every 2^k system clocks. k is CTRL[3:0], and any value above 8 acts as 8. A compare match never clears the counter.
- R3: When the counter wraps from 0xFFFF to 0x0000, FLAGS bit 3 (overflow) is set.
- R4: Capture input 1 passes through a two-flop synchronizer. A valid edge stores into CAP1 (address 3) the counter value present just before the third rising clock edge after the pin changes, even if the counter increments on that same edge. The edge also sets FLAGS bit 0.
- R5: A valid edge on capture input 2 stores the counter into R2 (address 2) with the same timing as R4 and sets FLAGS bit 1. If a software write to R2 lands on the same edge, the capture wins.
- R6: CTRL bit 4 (channel 1) and CTRL bit 5 (channel 2) select the active edge: 1 means rising and 0 means falling. The opposite edge is ignored.
- R7: When the counter becomes equal to R1 (address 1), `cmp_out` toggles once and FLAGS bit 2 is set once. This holds even if the equality lasts many clocks within one prescaler tick. A write to R1 takes effect on the next clock. An equality that already exists when reset is released does not count.
- R8: FLAGS (address 5) is cleared by writing one to a bit. A flag that is set and cleared on the same edge stays set.
- R9: A capture that arrives while its channel's flag is still set overwrites the register and sets FLAGS bit 4 (channel 1) or bit 5 (channel 2).
- R10: `irq` is high exactly when some FLAGS bit in [3:0] is set and its enable is set. The enables are CTRL[8] for capture 1, CTRL[9] for capture 2, CTRL[10] for compare and CTRL[11] for overflow.
- R11: The read map is 0 CTRL[11:0], 1 R1, 2 R2, 3 CAP1, 4 COUNT, 5 FLAGS[5:0], and any other address reads zero. Writes to addresses 3 and 4 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| cap1_in | input | 1 | Asynchronous capture input 1 |
| cap2_in | input | 1 | Asynchronous capture input 2 |
| cmp_out | output | 1 | Compare toggle output |
| irq | output | 1 | Interrupt request |

## Verification
The bench checks the exact capture latency with the counter stepping every clock. A design that sampled after the increment, or that used a different number of synchronizer stages, would be off by one in the snapshot.

It holds a compare equality for hundreds of clocks at the slowest prescale and clears the flag while the equality lasts. A level-triggered compare would set the flag again and toggle the output repeatedly.

It lines up a software write or a flag clear on the same edge as a capture. A design with the wrong priority would lose the snapshot or drop the flag.

Random capture pulses, wrong-polarity edges, the prescale clamp and a full counter wrap complete the set.

// File: rtl/cap_cmp_timer.sv
module cap_cmp_timer #(
  parameter int CW   = 16,
  parameter int KMAX = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [2:0]    rd_addr,
  output logic [CW-1:0] rd_data,
  input  logic          cap1_in,
  input  logic          cap2_in,
  output logic          cmp_out,
  output logic          irq
);
  localparam int PW = (KMAX > 0) ? KMAX : 1;

  logic [CW-1:0] cnt, r1, r2, cap1;
  logic [11:0]   ctrl;
  logic [5:0]    flags;
  logic [PW-1:0] pre;
  logic [2:0]    s1, s2;
  logic          hit_q;

  logic [3:0]  k;
  logic [PW:0] mask_w;
  logic        tick, e1, e2, hit, cmp_evt, wrap;
  logic [5:0]  fset, fclr;

  assign k       = (ctrl[3:0] > 4'(KMAX)) ? 4'(KMAX) : ctrl[3:0];
  assign mask_w  = ((PW+1)'(1) << k) - (PW+1)'(1);
  assign tick    = (pre & mask_w[PW-1:0]) == mask_w[PW-1:0];
  assign wrap    = tick && (cnt == {CW{1'b1}});
  assign e1      = ctrl[4] ? (s1[1] & ~s1[2]) : (~s1[1] & s1[2]);
  assign e2      = ctrl[5] ? (s2[1] & ~s2[2]) : (~s2[1] & s2[2]);
  assign hit     = (cnt == r1);
  assign cmp_evt = hit & ~hit_q;
  assign fset    = {e2 & flags[1], e1 & flags[0], wrap, cmp_evt, e2, e1};
  assign fclr    = (wr_en && wr_addr == 3'd5) ? wr_data[5:0] : 6'd0;
  assign irq     = |(flags[3:0] & ctrl[11:8]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; r1 <= '0; r2 <= '0; cap1 <= '0; ctrl <= '0;
      flags <= '0; pre <= '0; s1 <= '0; s2 <= '0;
      hit_q <= 1'b1; cmp_out <= 1'b0;
    end else begin
      pre   <= pre + 1'b1;
      s1    <= {s1[1:0], cap1_in};
      s2    <= {s2[1:0], cap2_in};
      hit_q <= hit;
      if (tick) cnt <= cnt + 1'b1;
      if (cmp_evt) cmp_out <= ~cmp_out;
      if (e1) cap1 <= cnt;
      if (wr_en && wr_addr == 3'd0) ctrl <= wr_data[11:0];
      if (wr_en && wr_addr == 3'd1) r1 <= wr_data;
      if (e2) r2 <= cnt;
      else if (wr_en && wr_addr == 3'd2) r2 <= wr_data;
      flags <= fset | (flags & ~fclr);
    end
  end

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = CW'(ctrl);
      3'd1:    rd_data = r1;
      3'd2:    rd_data = r2;
      3'd3:    rd_data = cap1;
      3'd4:    rd_data = cnt;
      3'd5:    rd_data = CW'(flags);
      default: rd_data = '0;
    endcase
  end

  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
  a_r2_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wrap) |=> cnt == $past(cnt) + 1'b1);
  a_r3_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flags[3] && cnt == '0);
  a_r4_cap1_value: assert property (@(posedge clk) disable iff (!rst_n)
    e1 |=> cap1 == $past(cnt) && flags[0]);
  a_r5_cap2_value: assert property (@(posedge clk) disable iff (!rst_n)
    e2 |=> r2 == $past(cnt) && flags[1]);
  a_r7_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt |=> cmp_out != $past(cmp_out) && flags[2]);
  a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_evt |=> $stable(cmp_out));
  a_r9_overrun1: assert property (@(posedge clk) disable iff (!rst_n)
    (e1 && flags[0]) |=> flags[4]);
  a_r10_no_flag_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[3:0] == 4'd0) |-> !irq);
endmodule

// File: tb/cap_cmp_timer_tb_top.sv
module cap_cmp_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic cap1_in = 1'b0, cap2_in = 1'b0;
  logic cmp_out, irq;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  cap_cmp_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cap1_in(cap1_in), .cap2_in(cap2_in),
    .cmp_out(cmp_out), .irq(irq));

  function automatic logic [15:0] exp_cap(input logic [15:0] c);
    return c + 16'd2;
  endfunction

  function automatic logic [15:0] exp_adv(input logic [15:0] c, input int cyc, input int k);
    int kk = (k > 8) ? 8 : k;
    return c + 16'(cyc >> kk);
  endfunction

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] c, v, v2;
    logic o0;
    void'($urandom(32'h00C0FFEE));
    step(3);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk(v == 16'd0, "R1 reset register", v, 16'd0);
    end
    chk(cmp_out == 1'b0 && irq == 1'b0, "R1 reset outputs", {cmp_out, irq}, 16'd0);
    step();
    rst_n = 1'b1;
    step();

    wr(3'd1, 16'hF000);
    wr(3'd0, 16'h0030);
    rd(3'd0, v);
    chk(v == 16'h0030, "R11 ctrl readback", v, 16'h0030);
    rd(3'd4, c); wr(3'd4, 16'hBEEF); rd(3'd4, v);
    chk(v == c + 16'd1, "R11 count write ignored", v, c + 16'd1);
    rd(3'd3, c); wr(3'd3, 16'h1357); rd(3'd3, v);
    chk(v == c, "R11 cap1 write ignored", v, c);
    rd(3'd7, v);
    chk(v == 16'd0, "R11 unmapped address", v, 16'd0);

    wr(3'd0, 16'h0033);
    rd(3'd4, c); step(64); rd(3'd4, v);
    chk(v == exp_adv(c, 64, 3), "R2 prescale k=3", v, exp_adv(c, 64, 3));
    wr(3'd0, 16'h003F);
    rd(3'd4, c); step(512); rd(3'd4, v);
    chk(v == exp_adv(c, 512, 15), "R2 prescale clamp", v, exp_adv(c, 512, 15));
    wr(3'd0, 16'h0030);

    wr(3'd5, 16'h003F);
    rd(3'd4, c); cap1_in = 1'b1; step(3); rd(3'd3, v);
    chk(v == exp_cap(c), "R4 cap1 snapshot", v, exp_cap(c));
    rd(3'd5, v);
    chk(v[0] == 1'b1 && v[4] == 1'b0, "R4 cap1 flag", v, 16'h0001);
    cap1_in = 1'b0; step(4);
    rd(3'd4, c); cap1_in = 1'b1; step(3); rd(3'd3, v); rd(3'd5, v2);
    chk(v == exp_cap(c) && v2[4], "R9 overrun ch1", v2, 16'h0011);
    cap1_in = 1'b0; step(4);

    wr(3'd5, 16'h003F);
    rd(3'd4, c); cap2_in = 1'b1; step(2);
    wr(3'd2, 16'h1234);
    rd(3'd2, v);
    chk(v == exp_cap(c), "R5 capture beats write", v, exp_cap(c));
    rd(3'd5, v);
    chk(v[1] == 1'b1, "R5 cap2 flag", v, 16'h0002);
    cap2_in = 1'b0; step(4);
    wr(3'd2, 16'h4321); rd(3'd2, v);
    chk(v == 16'h4321, "R5 software write to R2", v, 16'h4321);

    wr(3'd0, 16'h0010);
    wr(3'd5, 16'h003F);
    cap2_in = 1'b1; step(5);
    rd(3'd2, v); rd(3'd5, v2);
    chk(v == 16'h4321 && v2[1] == 1'b0, "R6 rising ignored on falling channel", v, 16'h4321);
    rd(3'd4, c); cap2_in = 1'b0; step(3); rd(3'd2, v);
    chk(v == exp_cap(c), "R6 falling edge capture", v, exp_cap(c));
    wr(3'd0, 16'h0030);
    wr(3'd5, 16'h003F);

    cap1_in = 1'b1; step(3); cap1_in = 1'b0; step(4);
    cap1_in = 1'b1; step(2);
    wr(3'd5, 16'h0001);
    rd(3'd5, v);
    chk(v[0] == 1'b1 && v[4] == 1'b1, "R8 set beats clear", v, 16'h0011);
    wr(3'd5, 16'h0011); rd(3'd5, v);
    chk(v == 16'd0, "R8 write one clears", v, 16'd0);
    cap1_in = 1'b0; step(4);

    wr(3'd5, 16'h003F);
    cap1_in = 1'b1; step(3);
    wr(3'd0, 16'h0430);
    chk(irq == 1'b0, "R10 masked cause", {15'd0, irq}, 16'd0);
    wr(3'd0, 16'h0530);
    chk(irq == 1'b1, "R10 enabled cause", {15'd0, irq}, 16'd1);
    wr(3'd5, 16'h003F);
    chk(irq == 1'b0, "R10 cleared cause", {15'd0, irq}, 16'd0);
    cap1_in = 1'b0; step(4);
    wr(3'd0, 16'h0030);

    o0 = cmp_out;
    rd(3'd4, c); wr(3'd1, c + 16'd10);
    step(5);
    chk(cmp_out == o0, "R7 no early toggle", {15'd0, cmp_out}, {15'd0, o0});
    step(10);
    chk(cmp_out == ~o0, "R7 toggle on match", {15'd0, cmp_out}, {15'd0, ~o0});
    rd(3'd5, v);
    chk(v[2] == 1'b1, "R7 compare flag", v, 16'h0004);
    rd(3'd4, v);
    chk(v == c + 16'd16, "R2 no reset on match", v, c + 16'd16);

    wr(3'd0, 16'h0038);
    wr(3'd5, 16'h003F);
    o0 = cmp_out;
    rd(3'd4, c); wr(3'd1, c + 16'd1);
    for (int i = 0; i < 600; i++) begin
      rd(3'd5, v);
      if (v[2]) break;
      step();
    end
    chk(v[2] == 1'b1, "R7 slow match seen", v, 16'h0004);
    wr(3'd5, 16'h0004);
    step(100);
    rd(3'd5, v);
    chk(v[2] == 1'b0, "R7 single flag per match", v, 16'd0);
    chk(cmp_out == ~o0, "R7 single toggle per match", {15'd0, cmp_out}, {15'd0, ~o0});
    wr(3'd0, 16'h0030);

    for (int it = 0; it < 40; it++) begin
      int ch = int'($urandom_range(1, 0));
      step(int'($urandom_range(40, 5)));
      wr(3'd5, 16'h003F);
      rd(3'd4, c);
      if (ch == 0) cap1_in = 1'b1; else cap2_in = 1'b1;
      step(3);
      rd(ch == 0 ? 3'd3 : 3'd2, v);
      rd(3'd5, v2);
      if (ch == 0) chk(v == exp_cap(c) && v2[1:0] == 2'b01, "R4 random capture", v, exp_cap(c));
      else         chk(v == exp_cap(c) && v2[1:0] == 2'b10, "R5 random capture", v, exp_cap(c));
      cap1_in = 1'b0; cap2_in = 1'b0;
      step(4);
      rd(3'd5, v2);
      chk(v2[1:0] == ((ch == 0) ? 2'b01 : 2'b10), "R6 falling edge ignored", v2, 16'(ch == 0 ? 1 : 2));
    end

    wr(3'd5, 16'h003F);
    for (int i = 0; i < 70000; i++) begin
      rd(3'd4, c);
      if (c == 16'hFFF0) break;
      step();
    end
    rd(3'd5, v);
    chk(v[3] == 1'b0, "R3 no flag before wrap", v, 16'd0);
    step(20);
    rd(3'd4, c); rd(3'd5, v);
    chk(c == 16'h0004, "R3 counter wrapped", c, 16'h0004);
    chk(v[3] == 1'b1, "R3 overflow flag", v, 16'h0008);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule